// File: doc/BRIEF.md
# Paged Ethernet Controller Register Bank

This block is the host-side control register bank of a small Ethernet controller. The host reaches it through a window of 16 byte-wide locations. Location 0 is always the command register. Bits 7:6 of the command register select one of four register pages, and that page decides what every other location means. The bank holds the receive ring geometry (start, stop, boundary and current page), the transmit page and length, the remote-DMA address and count, the receive and data configuration bytes, the six-byte station address and the eight-byte multicast hash. It also holds the interrupt status and mask registers and drives one level-sensitive interrupt line.

The transmit and receive datapaths sit outside the block and connect through plain pins. They raise status events on one-cycle strobes and supply the last receive status byte. In return they see the stored configuration and a one-cycle transmit request. No data moves through this block, so no pin uses a valid/ready handshake. A host write takes effect at the clock edge where `wr_en_i` is sampled high. Reads are combinational from `addr_i` and have no side effects.

Top module: `nic_regbank`

## Requirements
- R1: Reset loads status 0x80, mask 0x00 and command 0x01, and clears the transmit status and all other stored bytes. The interrupt line is low after reset.
- R2: Location 0 reaches the command register on every page. Every other location is decoded together with the page in command bits 7:6. A write on one page leaves the registers of the other pages unchanged.
- R3: `irq_o` is high exactly when (status AND mask) has a non-zero bit among bits 6:0. Status bit 7 (reset) never raises the line.
- R4: A page-0 write to location 7 clears each status bit 6:0 whose written bit is 1. Status bit 7 is not affected. If an event strobe hits in the same cycle as the clear, the event wins.
- R5: Each bit of `ev_set_i` sets the matching status bit 6:0. The bit encodings are: RX 0x01, TX 0x02, RX error 0x04, TX error 0x08, overwrite 0x10, counter 0x20, remote-DMA done 0x40.
- R6: Any command write with bit 0 (stop) at 0 clears status bit 7.
- R7: A command write with stop clear that has bit 3 (remote read) or bit 4 (remote write) set, while the remote count is zero, sets status bit 6 in the same edge. A non-zero count leaves bit 6 alone.
- R8: A command write with stop clear and bit 2 (transmit) set does four things. It raises `tx_req_o` for exactly the following cycle, with `tx_page_o` and `tx_len_o` holding the stored page and length. It sets the transmit status (page 0, location 4) to 0x01. It sets status bit 1. The stored command reads back with bit 2 cleared. With stop set, no request is made.
- R9: The transmit length (page 0, locations 5 and 6), remote address (8 and 9) and remote count (10 and 11) are 16-bit values written as low and high bytes. The remote address also reads back as bytes on locations 8 and 9.
- R10: Ring start (page 0, location 1) and stop (page 0, location 2) accept a value at or below PAGE_LIMIT (default 0x80). Both read back on page 2 at the same locations. Boundary (page 0, location 3) and current page (page 1, location 7) accept only values below PAGE_LIMIT. A rejected write keeps the old value.
- R11: On page 0, location 10 reads 0x50 and location 11 reads 0x43. On page 3, locations 5 and 6 read 0x40. Every location with no readable register reads 0x00.
- R12: Page 1 locations 1 to 6 hold station bytes 0 to 5, and locations 8 to 15 hold hash bytes 0 to 7. Each byte is readable and writable there. Byte i appears at bits 8i+7:8i of `station_o` and `hash_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Window location |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Read byte for `addr_i` on the current page |
| ev_set_i | input | 7 | Status event strobes from the datapaths |
| rx_status_i | input | 8 | Last receive status, readable on page 0, location 12 |
| irq_o | output | 1 | Level interrupt |
| tx_req_o | output | 1 | One-cycle transmit request |
| tx_page_o | output | 8 | Transmit start page |
| tx_len_o | output | 16 | Transmit byte count |
| cmd_o | output | 8 | Stored command byte |
| ring_start_o | output | 8 | Ring start page |
| ring_stop_o | output | 8 | Ring stop page |
| ring_bnry_o | output | 8 | Boundary page |
| ring_curr_o | output | 8 | Current write page |
| rdma_addr_o | output | 16 | Remote-DMA start address |
| rdma_cnt_o | output | 16 | Remote-DMA byte count |
| rx_cfg_o | output | 8 | Receive configuration byte |
| data_cfg_o | output | 8 | Data configuration byte |
| station_o | output | 48 | Station address bytes |
| hash_o | output | 64 | Multicast hash bytes |

## Verification
The assertions check several rules on every cycle. A transmit request only follows an accepted transmit command. A status clear leaves no written bit set unless an event arrived in the same cycle. A running command always drops the reset bit. A remote command with zero count always sets the done bit. The ring pointers never hold a value past the limit. The interrupt never rises with status bits 6:0 all clear. Other behaviour only shows in the bench scenarios:
- the full interrupt truth table across all mask values;
- the accept and reject boundary for every possible pointer byte;
- the page isolation;
- the exact readback of identity and unmapped locations.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  localparam int STA_BYTES  = 6;
  localparam int HASH_BYTES = 8;

  // command register bit positions
  localparam int CMD_STOP  = 0;
  localparam int CMD_TX    = 2;
  localparam int CMD_RREAD = 3;
  localparam int CMD_RWR   = 4;

  // status bit positions used inside the bank
  localparam int ST_TX    = 1;
  localparam int ST_RDONE = 6;
  localparam int ST_RST   = 7;

  typedef enum logic [4:0] {
    W_NONE, W_CMD, W_PSTART, W_PSTOP, W_BNRY, W_TPAGE, W_TLEN_LO, W_TLEN_HI,
    W_STCLR, W_RADDR_LO, W_RADDR_HI, W_RCNT_LO, W_RCNT_HI, W_RXCFG, W_DCFG,
    W_MASK, W_STA, W_CURR, W_HASH
  } wsel_e;

  typedef enum logic [4:0] {
    R_ZERO, R_CMD, R_BNRY, R_TXST, R_STAT, R_RADDR_LO, R_RADDR_HI, R_ID0,
    R_ID1, R_RXST, R_STA, R_CURR, R_HASH, R_PSTART, R_PSTOP, R_CFG40
  } rsel_e;

endpackage

// File: rtl/nic_addr_decode.sv
module nic_addr_decode
  import nic_regbank_pkg::*;
(
  input  logic [1:0] page_i,
  input  logic [3:0] off_i,
  output wsel_e      wsel_o,
  output rsel_e      rsel_o,
  output logic [2:0] idx_o
);
  always_comb begin
    wsel_o = W_NONE;
    rsel_o = R_ZERO;
    idx_o  = 3'd0;
    if (off_i == 4'h0) begin
      wsel_o = W_CMD;
      rsel_o = R_CMD;
    end else begin
      unique case (page_i)
        2'd0: begin
          case (off_i)
            4'h1: wsel_o = W_PSTART;
            4'h2: wsel_o = W_PSTOP;
            4'h3: begin wsel_o = W_BNRY;     rsel_o = R_BNRY;     end
            4'h4: begin wsel_o = W_TPAGE;    rsel_o = R_TXST;     end
            4'h5: wsel_o = W_TLEN_LO;
            4'h6: wsel_o = W_TLEN_HI;
            4'h7: begin wsel_o = W_STCLR;    rsel_o = R_STAT;     end
            4'h8: begin wsel_o = W_RADDR_LO; rsel_o = R_RADDR_LO; end
            4'h9: begin wsel_o = W_RADDR_HI; rsel_o = R_RADDR_HI; end
            4'ha: begin wsel_o = W_RCNT_LO;  rsel_o = R_ID0;      end
            4'hb: begin wsel_o = W_RCNT_HI;  rsel_o = R_ID1;      end
            4'hc: begin wsel_o = W_RXCFG;    rsel_o = R_RXST;     end
            4'he: wsel_o = W_DCFG;
            4'hf: wsel_o = W_MASK;
            default: ;
          endcase
        end
        2'd1: begin
          if (off_i == 4'h7) begin
            wsel_o = W_CURR;
            rsel_o = R_CURR;
          end else if (off_i[3]) begin
            wsel_o = W_HASH;
            rsel_o = R_HASH;
            idx_o  = off_i[2:0];
          end else begin
            wsel_o = W_STA;
            rsel_o = R_STA;
            idx_o  = off_i[2:0] - 3'd1;
          end
        end
        2'd2: begin
          if (off_i == 4'h1) rsel_o = R_PSTART;
          else if (off_i == 4'h2) rsel_o = R_PSTOP;
        end
        default: begin
          if (off_i == 4'h5 || off_i == 4'h6) rsel_o = R_CFG40;
        end
      endcase
    end
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_regbank_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we_i,
  input  logic [SW-1:0] mask_wd_i,
  input  logic          clr_we_i,
  input  logic [SW-2:0] clr_bits_i,
  input  logic [SW-2:0] set_bits_i,
  input  logic          rst_bit_clr_i,
  output logic [SW-1:0] stat_o,
  output logic [SW-1:0] mask_o,
  output logic          irq_o
);
  logic [SW-1:0] stat_q, mask_q;
  logic [SW-2:0] keep;

  assign keep = clr_we_i ? ~clr_bits_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= SW'(1) << ST_RST;
      mask_q <= '0;
    end else begin
      stat_q[SW-2:0] <= (stat_q[SW-2:0] & keep) | set_bits_i;
      if (rst_bit_clr_i) stat_q[SW-1] <= 1'b0;
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q[SW-2:0] & mask_q[SW-2:0]);
endmodule

// File: rtl/nic_ring_ptrs.sv
module nic_ring_ptrs #(
  parameter int       PW         = 8,
  parameter logic [PW-1:0] PAGE_LIMIT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    we_i,     // start, stop, boundary, current
  input  logic [PW-1:0] wd_i,
  output logic [PW-1:0] start_o,
  output logic [PW-1:0] stop_o,
  output logic [PW-1:0] bnry_o,
  output logic [PW-1:0] curr_o
);
  logic [PW-1:0] ptr_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_ptr
    // start and stop may equal the limit; boundary and current must stay below
    localparam bit INCL = (g < 2);
    logic ok;
    assign ok = INCL ? (wd_i <= PAGE_LIMIT) : (wd_i < PAGE_LIMIT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (we_i[g] && ok) ptr_q[g] <= wd_i;
    end
  end

  assign start_o = ptr_q[0];
  assign stop_o  = ptr_q[1];
  assign bnry_o  = ptr_q[2];
  assign curr_o  = ptr_q[3];
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter logic [7:0] PAGE_LIMIT = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [6:0]  ev_set_i,
  input  logic [7:0]  rx_status_i,
  output logic        irq_o,
  output logic        tx_req_o,
  output logic [7:0]  tx_page_o,
  output logic [15:0] tx_len_o,
  output logic [7:0]  cmd_o,
  output logic [7:0]  ring_start_o,
  output logic [7:0]  ring_stop_o,
  output logic [7:0]  ring_bnry_o,
  output logic [7:0]  ring_curr_o,
  output logic [15:0] rdma_addr_o,
  output logic [15:0] rdma_cnt_o,
  output logic [7:0]  rx_cfg_o,
  output logic [7:0]  data_cfg_o,
  output logic [8*STA_BYTES-1:0]  station_o,
  output logic [8*HASH_BYTES-1:0] hash_o
);
  localparam logic [7:0] ID_LO = 8'h50;
  localparam logic [7:0] ID_HI = 8'h43;

  wsel_e      wsel;
  rsel_e      rsel;
  logic [2:0] idx;

  logic [7:0]  cmd_q, txst_q, tpage_q, rxcfg_q, dcfg_q;
  logic [15:0] tlen_q, raddr_q, rcnt_q;
  logic        txreq_q;
  logic [7:0]  sta_q  [STA_BYTES];
  logic [7:0]  hash_q [HASH_BYTES];
  logic [7:0]  stat_w, mask_w;

  nic_addr_decode u_dec (
    .page_i (cmd_q[7:6]),
    .off_i  (addr_i),
    .wsel_o (wsel),
    .rsel_o (rsel),
    .idx_o  (idx)
  );

  logic we_cmd, go, tx_go, rdone_set;
  assign we_cmd    = wr_en_i && (wsel == W_CMD);
  assign go        = we_cmd && !wdata_i[CMD_STOP];
  assign tx_go     = go && wdata_i[CMD_TX];
  assign rdone_set = go && (wdata_i[CMD_RREAD] || wdata_i[CMD_RWR]) && (rcnt_q == 16'd0);

  logic [6:0] set_bits;
  always_comb begin
    set_bits = ev_set_i;
    if (rdone_set) set_bits[ST_RDONE] = 1'b1;
    if (tx_go)     set_bits[ST_TX]    = 1'b1;
  end

  nic_irq_unit #(.SW(8)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mask_we_i     (wr_en_i && (wsel == W_MASK)),
    .mask_wd_i     (wdata_i),
    .clr_we_i      (wr_en_i && (wsel == W_STCLR)),
    .clr_bits_i    (wdata_i[6:0]),
    .set_bits_i    (set_bits),
    .rst_bit_clr_i (go),
    .stat_o        (stat_w),
    .mask_o        (mask_w),
    .irq_o         (irq_o)
  );

  logic [3:0] ptr_we;
  assign ptr_we = {wr_en_i && (wsel == W_CURR), wr_en_i && (wsel == W_BNRY),
                   wr_en_i && (wsel == W_PSTOP), wr_en_i && (wsel == W_PSTART)};

  nic_ring_ptrs #(.PW(8), .PAGE_LIMIT(PAGE_LIMIT)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ptr_we),
    .wd_i    (wdata_i),
    .start_o (ring_start_o),
    .stop_o  (ring_stop_o),
    .bnry_o  (ring_bnry_o),
    .curr_o  (ring_curr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h01;
      txst_q  <= '0;
      tpage_q <= '0;
      tlen_q  <= '0;
      raddr_q <= '0;
      rcnt_q  <= '0;
      rxcfg_q <= '0;
      dcfg_q  <= '0;
      txreq_q <= 1'b0;
    end else begin
      txreq_q <= tx_go;
      if (tx_go) txst_q <= 8'h01;
      if (wr_en_i) begin
        case (wsel)
          W_CMD:      cmd_q <= tx_go ? (wdata_i & ~(8'h1 << CMD_TX)) : wdata_i;
          W_TPAGE:    tpage_q <= wdata_i;
          W_TLEN_LO:  tlen_q[7:0]   <= wdata_i;
          W_TLEN_HI:  tlen_q[15:8]  <= wdata_i;
          W_RADDR_LO: raddr_q[7:0]  <= wdata_i;
          W_RADDR_HI: raddr_q[15:8] <= wdata_i;
          W_RCNT_LO:  rcnt_q[7:0]   <= wdata_i;
          W_RCNT_HI:  rcnt_q[15:8]  <= wdata_i;
          W_RXCFG:    rxcfg_q <= wdata_i;
          W_DCFG:     dcfg_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < STA_BYTES; g++) begin : g_sta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta_q[g] <= '0;
      else if (wr_en_i && wsel == W_STA && idx == 3'(g)) sta_q[g] <= wdata_i;
    end
    assign station_o[8*g +: 8] = sta_q[g];
  end

  for (genvar g = 0; g < HASH_BYTES; g++) begin : g_hash
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hash_q[g] <= '0;
      else if (wr_en_i && wsel == W_HASH && idx == 3'(g)) hash_q[g] <= wdata_i;
    end
    assign hash_o[8*g +: 8] = hash_q[g];
  end

  always_comb begin
    case (rsel)
      R_CMD:      rdata_o = cmd_q;
      R_BNRY:     rdata_o = ring_bnry_o;
      R_TXST:     rdata_o = txst_q;
      R_STAT:     rdata_o = stat_w;
      R_RADDR_LO: rdata_o = raddr_q[7:0];
      R_RADDR_HI: rdata_o = raddr_q[15:8];
      R_ID0:      rdata_o = ID_LO;
      R_ID1:      rdata_o = ID_HI;
      R_RXST:     rdata_o = rx_status_i;
      R_STA:      rdata_o = (idx < 3'(STA_BYTES)) ? sta_q[idx] : 8'h00;
      R_CURR:     rdata_o = ring_curr_o;
      R_HASH:     rdata_o = hash_q[idx];
      R_PSTART:   rdata_o = ring_start_o;
      R_PSTOP:    rdata_o = ring_stop_o;
      R_CFG40:    rdata_o = 8'h40;
      default:    rdata_o = 8'h00;
    endcase
  end

  assign cmd_o       = cmd_q;
  assign tx_req_o    = txreq_q;
  assign tx_page_o   = tpage_q;
  assign tx_len_o    = tlen_q;
  assign rdma_addr_o = raddr_q;
  assign rdma_cnt_o  = rcnt_q;
  assign rx_cfg_o    = rxcfg_q;
  assign data_cfg_o  = dcfg_q;
endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk #(
  parameter logic [7:0] PAGE_LIMIT = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en_i,
  input logic [3:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [6:0]  ev_set_i,
  input logic [7:0]  cmd_o,
  input logic        irq_o,
  input logic        tx_req_o,
  input logic [15:0] rdma_cnt_o,
  input logic [7:0]  stat,
  input logic [7:0]  mask,
  input logic [7:0]  ring_start_o,
  input logic [7:0]  ring_stop_o,
  input logic [7:0]  ring_bnry_o,
  input logic [7:0]  ring_curr_o
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (stat == 8'h80 && mask == 8'h00 && !irq_o));

  a_r8_txreq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> $past(wr_en_i && addr_i == 4'h0 && wdata_i[2] && !wdata_i[0]));

  a_r4_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i && addr_i == 4'h7 && cmd_o[7:6] == 2'b00 && ev_set_i == 7'd0)
      |-> ((stat[6:0] & $past(wdata_i[6:0])) == 7'd0));

  a_r6_run_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i && addr_i == 4'h0 && !wdata_i[0]) |-> !stat[7]);

  a_r7_zero_count_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i && addr_i == 4'h0 && !wdata_i[0] && (wdata_i[3] || wdata_i[4])
          && rdma_cnt_o == 16'd0) |-> stat[6]);

  a_r3_no_irq_without_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[6:0] == 7'd0) |-> !irq_o);

  a_r10_ptrs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ring_start_o <= PAGE_LIMIT && ring_stop_o <= PAGE_LIMIT &&
    ring_bnry_o < PAGE_LIMIT && ring_curr_o < PAGE_LIMIT);
endmodule

bind nic_regbank nic_regbank_chk #(.PAGE_LIMIT(PAGE_LIMIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .ev_set_i     (ev_set_i),
  .cmd_o        (cmd_o),
  .irq_o        (irq_o),
  .tx_req_o     (tx_req_o),
  .rdma_cnt_o   (rdma_cnt_o),
  .stat         (stat_w),
  .mask         (mask_w),
  .ring_start_o (ring_start_o),
  .ring_stop_o  (ring_stop_o),
  .ring_bnry_o  (ring_bnry_o),
  .ring_curr_o  (ring_curr_o)
);

// File: tb/nic_regbank_bench.sv
module nic_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = 4'h0;
  logic [7:0]  wdata_i = 8'h00;
  logic [6:0]  ev_set_i = 7'd0;
  logic [7:0]  rx_status_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        irq_o, tx_req_o;
  logic [7:0]  tx_page_o, cmd_o, ring_start_o, ring_stop_o, ring_bnry_o, ring_curr_o;
  logic [7:0]  rx_cfg_o, data_cfg_o;
  logic [15:0] tx_len_o, rdma_addr_o, rdma_cnt_o;
  logic [47:0] station_o;
  logic [63:0] hash_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  nic_regbank u_nic_regbank (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [7:0] d, input logic [6:0] e);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; ev_set_i = e;
    @(negedge clk);
    wr_en_i = 1'b0; ev_set_i = 7'd0;
  endtask

  task automatic ev(input logic [6:0] e);
    @(negedge clk); ev_set_i = e;
    @(negedge clk); ev_set_i = 7'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic page(input logic [1:0] p);
    wr(4'h0, {p, 6'h21});   // stop set, no remote DMA: no side effects
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, rv); chk("R1 cmd", rv, 8'h01);
    rd(4'h7, rv); chk("R1 status", rv, 8'h80);
    rd(4'h4, rv); chk("R1 txstat", rv, 8'h00);
    chk("R1 irq", irq_o, 1'b0);
    // R1 mask is zero: events do not raise irq
    ev(7'h7f); chk("R1 mask zero", irq_o, 1'b0);
    wr(4'h7, 8'h7f);
    // R3 reset bit alone never raises irq
    wr(4'hf, 8'hff); chk("R3 reset bit no irq", irq_o, 1'b0);
    // R4 bit 7 unaffected by clear
    wr(4'h7, 8'hff); rd(4'h7, rv); chk("R4 bit7 kept", rv, 8'h80);
    wr(4'hf, 8'h00);
    // R6 stop clear drops reset bit
    wr(4'h0, 8'h22); rd(4'h7, rv); chk("R6 reset bit cleared", rv, 8'h00);
    rd(4'h0, rv); chk("R2 cmd readback", rv, 8'h22);

    // R5/R4 sweep of clear masks
    for (int m = 0; m < 128; m++) begin
      ev(7'h7f);
      rd(4'h7, rv); chk("R5 events set", rv, 8'h7f);
      wr(4'h7, 8'(m));
      rd(4'h7, rv); chk("R4 clear mask", rv, 8'h7f & ~8'(m));
      wr(4'h7, 8'h7f);
    end
    // R4 event wins over same-cycle clear
    wr_ev(4'h7, 8'h01, 7'h01); rd(4'h7, rv); chk("R4 event wins", rv, 8'h01);
    wr(4'h7, 8'h7f);

    // R3 irq truth table
    for (int p = 0; p < 5; p++) begin
      logic [6:0] pat;
      pat = (p == 0) ? 7'h00 : (p == 1) ? 7'h01 : (p == 2) ? 7'h40 : (p == 3) ? 7'h55 : 7'h2a;
      for (int k = 0; k < 256; k++) begin
        wr(4'h7, 8'h7f);
        ev(pat);
        wr(4'hf, 8'(k));
        #1 chk("R3 irq", irq_o, |({1'b0, pat} & 8'(k) & 8'h7f));
      end
    end
    wr(4'hf, 8'h00);
    wr(4'h7, 8'h7f);

    // R7 remote-DMA done with zero count
    wr(4'h0, 8'h0a); rd(4'h7, rv); chk("R7 remote read zero count", rv[6], 1'b1);
    wr(4'h7, 8'h7f);
    wr(4'h0, 8'h12); rd(4'h7, rv); chk("R7 remote write zero count", rv[6], 1'b1);
    wr(4'h7, 8'h7f);
    wr(4'ha, 8'h05); chk("R9 rcnt lo", rdma_cnt_o, 16'h0005);
    wr(4'hb, 8'h01); chk("R9 rcnt hi", rdma_cnt_o, 16'h0105);
    wr(4'h0, 8'h0a); rd(4'h7, rv); chk("R7 nonzero count", rv[6], 1'b0);
    wr(4'h0, 8'h22);

    // R9 remote address bytes
    wr(4'h8, 8'h34); wr(4'h9, 8'h12);
    rd(4'h8, rv); chk("R9 raddr lo", rv, 8'h34);
    rd(4'h9, rv); chk("R9 raddr hi", rv, 8'h12);
    chk("R9 raddr port", rdma_addr_o, 16'h1234);

    // R8 transmit
    wr(4'h4, 8'h40); wr(4'h5, 8'h3c); wr(4'h6, 8'h05);
    wr(4'h7, 8'h7f);
    wr(4'h0, 8'h26);
    chk("R8 tx_req high", tx_req_o, 1'b1);
    chk("R8 tx_page", tx_page_o, 8'h40);
    chk("R8 tx_len", tx_len_o, 16'h053c);
    @(negedge clk); chk("R8 single pulse", tx_req_o, 1'b0);
    rd(4'h0, rv); chk("R8 cmd tx bit cleared", rv, 8'h22);
    rd(4'h4, rv); chk("R8 txstat", rv, 8'h01);
    rd(4'h7, rv); chk("R8 status tx bit", rv, 8'h02);
    wr(4'h7, 8'h7f);
    wr(4'h0, 8'h25); chk("R8 stopped no request", tx_req_o, 1'b0);
    rd(4'h7, rv); chk("R8 stopped no status", rv, 8'h00);

    // R10 pointer limits: start and stop
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      page(2'd0); wr(4'h1, 8'(v)); page(2'd2);
      if (v <= 8'h80) prev = 8'(v);
      rd(4'h1, rv); chk("R10 start", rv, prev);
    end
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      page(2'd0); wr(4'h2, 8'(v)); page(2'd2);
      if (v <= 8'h80) prev = 8'(v);
      rd(4'h2, rv); chk("R10 stop", rv, prev);
    end
    page(2'd0);
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(4'h3, 8'(v));
      if (v < 8'h80) prev = 8'(v);
      rd(4'h3, rv); chk("R10 boundary", rv, prev);
    end
    page(2'd1);
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(4'h7, 8'(v));
      if (v < 8'h80) prev = 8'(v);
      rd(4'h7, rv); chk("R10 current", rv, prev);
    end

    // R12 station and hash bytes
    for (int i = 0; i < 6; i++) wr(4'(i + 1), 8'(8'ha0 + i));
    for (int j = 0; j < 8; j++) wr(4'(j + 8), 8'(8'h10 * j + 3));
    for (int i = 0; i < 6; i++) begin
      rd(4'(i + 1), rv); chk("R12 station read", rv, 8'(8'ha0 + i));
      chk("R12 station port", station_o[8*i +: 8], 8'(8'ha0 + i));
    end
    for (int j = 0; j < 8; j++) begin
      rd(4'(j + 8), rv); chk("R12 hash read", rv, 8'(8'h10 * j + 3));
      chk("R12 hash port", hash_o[8*j +: 8], 8'(8'h10 * j + 3));
    end

    // R2 page isolation
    page(2'd0);
    for (int i = 1; i < 3; i++) begin
      rd(4'(i), rv); chk("R2 page0 unmapped read", rv, 8'h00);
    end
    wr(4'h8, 8'h77);
    page(2'd1);
    rd(4'h8, rv); chk("R2 hash untouched by page0", rv, 8'h03);
    rd(4'h1, rv); chk("R2 station untouched", rv, 8'ha0);
    page(2'd3);
    rd(4'h0, rv); chk("R2 cmd on page3", rv, 8'he1);

    // R11 identity and fixed reads
    rd(4'h5, rv); chk("R11 page3 loc5", rv, 8'h40);
    rd(4'h6, rv); chk("R11 page3 loc6", rv, 8'h40);
    rd(4'h3, rv); chk("R11 page3 loc3", rv, 8'h00);
    rd(4'h4, rv); chk("R11 page3 loc4", rv, 8'h00);
    page(2'd2);
    rd(4'h5, rv); chk("R11 page2 unmapped", rv, 8'h00);
    page(2'd0);
    rd(4'ha, rv); chk("R11 id0", rv, 8'h50);
    rd(4'hb, rv); chk("R11 id1", rv, 8'h43);
    rd(4'hf, rv); chk("R11 mask unreadable", rv, 8'h00);
    rx_status_i = 8'h21;
    rd(4'hc, rv); chk("R2 rx status read", rv, 8'h21);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule